// File: doc/BRIEF.md
# Glitch-Free Synchronous Clock Stop Controller

This block decides, for each of nine derived clock outputs, whether that output toggles or rests low. Two of the outputs come from a host clock source and seven come from a bus clock source. Each output has its own software enable bit, held in one of two control bytes. Two active-low halt inputs can also silence the stoppable outputs: one for the host group and one for the bus group. A strap input can tell the block to ignore both halt inputs.

Every change of an output's on/off state is held back to a safe point. The block first waits for a rising edge of the free-running bus clock. It then waits for a falling edge of the affected output's own source, and the new state applies there. This way a high phase is never cut short and a new high phase never starts part way through. Stopped outputs rest low.

All logic runs on one fast sampling clock `clk`. The two sources are level inputs sampled on that clock, so each gated output is a registered copy of its source, one `clk` cycle late. For every output, a status bit shows the enable that is applied at present.

Top module: `clkstop_ctrl`

## Requirements
- R1: While `rst` is high and after it is released, every output in `gclk_o` and `status_o` is 0 until a state change is applied.
- R2: Output index map and enable bits. Index 0 is the free host clock, enabled by `host_en_i[0]`. Index 1 is the gated host clock, enabled by `host_en_i[2]`. Index 2 is the free bus clock, enabled by `bus_en_i[7]`. Indices 3 to 6 are gated bus clocks 0 to 3, enabled by `bus_en_i[0]` to `bus_en_i[3]`. Index 7 is bus auxiliary clock 0, enabled by `bus_en_i[5]`. Index 8 is bus auxiliary clock 1, enabled by `bus_en_i[6]`. Once settled, `status_o[i]` equals the effective enable, and an output toggles only when its status bit is 1.
- R3: With `halt_ignore_i`=0 and `host_halt_n_i`=0, index 1 is stopped whatever its enable bit says.
- R4: With `halt_ignore_i`=0 and `bus_halt_n_i`=0, indices 3 to 6 are stopped whatever their enable bits say.
- R5: Indices 0, 2, 7 and 8 follow only their enable bits; neither halt input affects them.
- R6: With `halt_ignore_i`=1, both halt inputs have no effect, and every output follows its enable bit alone.
- R7: A status bit changes only on a falling edge of that output's source, and only after a rising edge of the free bus source has been seen since the request. It never changes within 2 `clk` cycles of an input change.
- R8: Every high pulse on an output is the full source high width: 3 cycles for host outputs and 6 cycles for bus outputs in the bench setup. A stopped output rests low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all logic |
| rst | input | 1 | Synchronous active-high reset |
| src_host_i | input | 1 | Host clock source level |
| src_bus_i | input | 1 | Bus clock source level; also the reference for safe points |
| halt_ignore_i | input | 1 | 1 = ignore both halt inputs |
| host_halt_n_i | input | 1 | Active-low halt for the gated host clock |
| bus_halt_n_i | input | 1 | Active-low halt for the four gated bus clocks |
| host_en_i | input | CTL_W | Host enable byte (bits 0 and 2 used) |
| bus_en_i | input | CTL_W | Bus enable byte (bits 0-3, 5, 6, 7 used) |
| gclk_o | output | 9 | Gated clock outputs, index map in R2 |
| status_o | output | 9 | Currently applied enable per output |

## Verification
The bench builds the block with `SYNC_STAGES`=3 instead of the default 2. The extra synchronizer stage lengthens the path from request to applied change, and this tests that the hold-off check on early status changes and the settling windows still line up. The host source toggles every 3 cycles and the bus source every 6. Because of these rates, safe points on the host outputs often fall on the same cycle as a bus reference rise, which tests the case where arming and applying happen together. A continuous width monitor then catches any shortened pulse during the configuration changes.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  localparam int NUM_OUT     = 9;
  localparam int NUM_BUS_G   = 4;
  localparam int IDX_HOST_F  = 0;
  localparam int IDX_HOST_G  = 1;
  localparam int IDX_BUS_F   = 2;
  localparam int IDX_BUS_G0  = 3;
  localparam int IDX_BUS_A0  = 7;
  localparam int IDX_BUS_A1  = 8;
  // bit positions inside the control bytes
  localparam int HB_FREE     = 0;
  localparam int HB_GATED    = 2;
  localparam int BB_GATED0   = 0;
  localparam int BB_AUX0     = 5;
  localparam int BB_AUX1     = 6;
  localparam int BB_FREE     = 7;

  function automatic logic from_host(input int idx);
    return (idx == IDX_HOST_F) || (idx == IDX_HOST_G);
  endfunction
endpackage

// File: rtl/clkstop_decode.sv
module clkstop_decode
  import clkstop_pkg::*;
#(
  parameter int CTL_W = 8
) (
  input  logic               halt_ignore_i,
  input  logic               host_halt_n_i,
  input  logic               bus_halt_n_i,
  input  logic [CTL_W-1:0]   host_en_i,
  input  logic [CTL_W-1:0]   bus_en_i,
  output logic [NUM_OUT-1:0] want_o
);
  logic host_ok;
  logic bus_ok;

  assign host_ok = halt_ignore_i | host_halt_n_i;
  assign bus_ok  = halt_ignore_i | bus_halt_n_i;

  assign want_o[IDX_HOST_F] = host_en_i[HB_FREE];
  assign want_o[IDX_HOST_G] = host_en_i[HB_GATED] & host_ok;
  assign want_o[IDX_BUS_F]  = bus_en_i[BB_FREE];
  assign want_o[IDX_BUS_A0] = bus_en_i[BB_AUX0];
  assign want_o[IDX_BUS_A1] = bus_en_i[BB_AUX1];

  for (genvar g = 0; g < NUM_BUS_G; g++) begin : g_busg
    assign want_o[IDX_BUS_G0+g] = bus_en_i[BB_GATED0+g] & bus_ok;
  end

  logic unused_bits;
  assign unused_bits = ^{host_en_i, bus_en_i};
endmodule

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate (
  input  logic clk,
  input  logic rst,
  input  logic ref_rise_i,
  input  logic src_i,
  input  logic want_i,
  output logic gclk_o,
  output logic applied_o
);
  logic src_d;
  logic armed;
  logic pend;
  logic fall;

  assign fall = src_d & ~src_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_d     <= 1'b0;
      armed     <= 1'b0;
      pend      <= 1'b0;
      applied_o <= 1'b0;
      gclk_o    <= 1'b0;
    end else begin
      src_d  <= src_i;
      gclk_o <= src_i & applied_o;
      if (armed && fall) begin
        applied_o <= pend;
        armed     <= 1'b0;
      end
      if (ref_rise_i) begin
        armed <= 1'b1;
        pend  <= want_i;
      end
    end
  end

  // R7
  apply_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(applied_o) |-> ($past(fall) && $past(armed)));

  // R7
  hold_unarmed_chk: assert property (@(posedge clk) disable iff (rst)
    !armed |=> $stable(applied_o));

  // R8
  park_low_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(applied_o) |-> !gclk_o);

  // R8
  full_high_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gclk_o) |-> ($past(src_i) && !$past(src_d)));
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int CTL_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               src_host_i,
  input  logic               src_bus_i,
  input  logic               halt_ignore_i,
  input  logic               host_halt_n_i,
  input  logic               bus_halt_n_i,
  input  logic [CTL_W-1:0]   host_en_i,
  input  logic [CTL_W-1:0]   bus_en_i,
  output logic [NUM_OUT-1:0] gclk_o,
  output logic [NUM_OUT-1:0] status_o
);
  logic [NUM_OUT-1:0] want_raw;
  logic [NUM_OUT-1:0] want_s;
  logic               ref_d;
  logic               ref_rise;

  clkstop_decode #(.CTL_W(CTL_W)) u_decode (
    .halt_ignore_i (halt_ignore_i),
    .host_halt_n_i (host_halt_n_i),
    .bus_halt_n_i  (bus_halt_n_i),
    .host_en_i     (host_en_i),
    .bus_en_i      (bus_en_i),
    .want_o        (want_raw)
  );

  clkstop_sync #(.W(NUM_OUT), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (want_raw),
    .q_o (want_s)
  );

  always_ff @(posedge clk) begin
    if (rst) ref_d <= 1'b0;
    else     ref_d <= src_bus_i;
  end
  assign ref_rise = src_bus_i & ~ref_d;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    logic src_sel;
    if (from_host(i)) begin : g_host
      assign src_sel = src_host_i;
    end else begin : g_bus
      assign src_sel = src_bus_i;
    end
    clkstop_gate u_gate (
      .clk        (clk),
      .rst        (rst),
      .ref_rise_i (ref_rise),
      .src_i      (src_sel),
      .want_i     (want_s[i]),
      .gclk_o     (gclk_o[i]),
      .applied_o  (status_o[i])
    );
  end
endmodule

// File: tb/clkstop_ctrl_bench.sv
`timescale 1ns/1ps
module clkstop_ctrl_bench;
  localparam int N = 9;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic src_host = 1'b0, src_bus = 1'b0;
  logic ign = 1'b0, hh = 1'b1, bh = 1'b1;
  logic [7:0] hen = 8'h00, ben = 8'h00;
  logic [N-1:0] gclk, status;

  int checks = 0, fails = 0, cyc = 0, win_start = 0;
  int last_rise [N];
  int hi_cnt [N];
  logic [N-1:0] gclk_prev = '0;
  logic [N-1:0] cur_exp = '0;

  typedef struct { logic [N-1:0] exp; bit status_only; string req; } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  clkstop_ctrl #(.CTL_W(8), .SYNC_STAGES(3)) u_clkstop_ctrl (
    .clk(clk), .rst(rst), .src_host_i(src_host), .src_bus_i(src_bus),
    .halt_ignore_i(ign), .host_halt_n_i(hh), .bus_halt_n_i(bh),
    .host_en_i(hen), .bus_en_i(ben), .gclk_o(gclk), .status_o(status));

  // source generation: host toggles every 3 cycles, bus every 6
  int sdiv = 0;
  always @(negedge clk) begin
    sdiv <= (sdiv == 5) ? 0 : sdiv + 1;
    if (sdiv == 2 || sdiv == 5) src_host <= ~src_host;
    if (sdiv == 5) src_bus <= ~src_bus;
  end

  function automatic logic [N-1:0] model(input logic [7:0] h, input logic [7:0] b,
                                         input logic hn, input logic bn, input logic ig);
    logic [N-1:0] e;
    e[0] = h[0];                 // R2 free host
    e[1] = h[2] & (ig | hn);     // R3 gated host
    e[2] = b[7];                 // R5 free bus
    for (int k = 0; k < 4; k++) e[3+k] = b[k] & (ig | bn);  // R4
    e[7] = b[5];
    e[8] = b[6];
    return e;
  endfunction

  task automatic fail_line(input string req, input string what, input int act, input int exp);
    fails++;
    $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
  endtask

  // monitor: pulse widths (R8) and scoreboard pops
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!rst) begin
      for (int i = 0; i < N; i++) begin
        if (gclk[i] && !gclk_prev[i]) last_rise[i] = cyc;
        if (gclk[i]) hi_cnt[i]++;
        else if (hi_cnt[i] > 0) begin
          checks++;
          if (hi_cnt[i] != ((i < 2) ? 3 : 6))
            fail_line("R8", $sformatf("pulse width idx%0d", i), hi_cnt[i], (i < 2) ? 3 : 6);
          hi_cnt[i] = 0;
        end
      end
      gclk_prev = gclk;
      if (sb_q.size() > 0) begin
        item_t it;
        logic [N-1:0] act;
        it = sb_q.pop_front();
        checks++;
        if (status !== it.exp) fail_line(it.req, "status", status, it.exp);
        if (!it.status_only) begin
          for (int i = 0; i < N; i++) act[i] = (last_rise[i] > win_start);
          checks++;
          if (act !== it.exp) fail_line(it.req, "activity", act, it.exp);
          checks++;
          if ((gclk & ~it.exp) != 0) fail_line("R8", "stopped not low", gclk, 0);
        end
      end
    end
  end

  task automatic run_cfg(input logic [7:0] h, input logic [7:0] b, input logic hn,
                         input logic bn, input logic ig, input string req);
    logic [N-1:0] nexp;
    item_t it;
    hen = h; ben = b; hh = hn; bh = bn; ign = ig;
    nexp = model(h, b, hn, bn, ig);
    repeat (2) @(negedge clk);
    if (nexp != cur_exp) begin
      // R7: no change this early
      it.exp = cur_exp; it.status_only = 1'b1; it.req = "R7";
      sb_q.push_back(it);
    end
    repeat (45) @(negedge clk);
    win_start = cyc;
    repeat (30) @(negedge clk);
    it.exp = nexp; it.status_only = 1'b0; it.req = req;
    sb_q.push_back(it);
    repeat (2) @(negedge clk);
    cur_exp = nexp;
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin last_rise[i] = 0; hi_cnt[i] = 0; end
    hen = 8'h05; ben = 8'hEF;
    repeat (8) @(negedge clk);
    checks++;  // R1 during reset
    if (gclk !== '0 || status !== '0) fail_line("R1", "reset outputs", {gclk, status}, 0);
    rst = 1'b0;
    @(negedge clk);
    checks++;  // R1 right after release
    if (gclk !== '0 || status !== '0) fail_line("R1", "after release", {gclk, status}, 0);
    run_cfg(8'h05, 8'hEF, 1, 1, 0, "R2");
    run_cfg(8'h05, 8'hEF, 0, 1, 0, "R3");
    run_cfg(8'h05, 8'hEF, 1, 0, 0, "R4");
    run_cfg(8'h05, 8'hEF, 0, 0, 0, "R5");
    run_cfg(8'h05, 8'hEF, 0, 0, 1, "R6");
    run_cfg(8'h01, 8'hA5, 1, 1, 0, "R2");
    run_cfg(8'h04, 8'h5A, 0, 1, 1, "R6");
    run_cfg(8'h00, 8'h00, 1, 1, 0, "R8");
    run_cfg(8'h05, 8'hEF, 1, 1, 0, "R7");
    repeat (20) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule